// File: doc/BRIEF.md
# Interval Timer Channel

A single down-counting timer channel with a configurable count width (16 bits by default). It advances on a count-enable strobe (`tick_en`) rather than on a clock of its own. Its gate input can pause it or restart it. It drives one output line in one of six counting behaviours:

- terminal-count interrupt
- gate-retriggered one-shot
- periodic rate pulse
- square wave
- software-started strobe
- gate-started strobe

A host sequencer writes a count and a 3-bit behaviour code with a single strobe. The sequencer can read the running count at any time, and it can freeze a copy of the count into a snapshot register for a stable readback.

A written count of zero stands for the full range of the counter, 2^CNT_W ticks. Every write restarts the channel from the newly written value. The gate is sampled on the system clock. It can optionally pass through a synchronizer, and its reset level is a parameter, so that channels whose gate idles low do not see a false rising edge after reset.

Top module: `ivt_channel`

## Requirements
- R1: A written count of 0 behaves as 2^CNT_W ticks. In behaviour 0 with count 0, the output rises on the 65536th tick after the write.
- R2: A write makes `live_count` equal the written count on the next cycle and restarts the selected behaviour. After that, the counter moves only in cycles where `tick_en` is high.
- R3: Behaviour code 0 drives the output low from the write until N ticks have passed, then holds it high. The counter keeps decrementing through zero with wraparound.
- R4: Behaviour code 1 holds the count and keeps the output high until a gate rising edge. It then reloads N, drives the output low for N ticks, and drives it high again. A further rising edge at any time reloads and restarts the low interval. In this behaviour a low gate does not pause counting.
- R5: Behaviour code 2 reloads N every N ticks. At each reload the output goes low until the next tick, and no pulse is produced on the write itself.
- R6: Behaviour code 3 keeps the output high for (N+1)/2 ticks and low for N/2 ticks in each period, with integer division. The count steps down by two per tick. The low half reloads N with bit 0 cleared, and the high half reloads N.
- R7: Behaviour codes 4 and 5 drive the output low for one tick interval when N ticks have passed since the start. There is no reload and no second strobe. Code 4 starts on the write. Code 5 holds the count until a gate rising edge, which restarts it.
- R8: With the gate low, the counter holds in codes 0, 2, 3 and 4. In codes 2 and 3 the output is also forced high. A gate rising edge reloads N in codes 2 and 3.
- R9: Behaviour codes 6 and 7 act exactly as codes 2 and 3.
- R10: Reset selects behaviour 3 with count 0, and the output high. The count then steps 0, 0xFFFE, and so on.
- R11: A snapshot strobe copies the count present in that cycle into `snap_count`. The copy is held there until the next snapshot strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one timer tick per high cycle |
| gate_in | input | 1 | Gate level, sampled on clk |
| wr_stb | input | 1 | Write strobe for count and behaviour code |
| wr_count | input | CNT_W | Count to load, 0 meaning 2^CNT_W |
| wr_mode | input | 3 | Behaviour code 0 to 7 |
| snap_stb | input | 1 | Snapshot strobe |
| live_count | output | CNT_W | Running count |
| snap_count | output | CNT_W | Count frozen at the last snapshot |
| timer_out | output | 1 | Timer output line |

## Verification
A wrong reload value or a wrong reload selection shows up on `live_count` in the cycle right after the terminal tick, so the bench compares the count at and just after each period boundary. A stale run or started flag shows up differently: either a missing strobe or a second one, or a count that moves before its trigger. The bench therefore checks that the count is held before each gate edge and checks the output one and two ticks past each terminal. Gate-pause faults show up within the first cycle of a low gate, as a moving count or a low output.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

   typedef enum logic [2:0] {
      MD_TERM    = 3'd0,
      MD_ONESHOT = 3'd1,
      MD_RATE    = 3'd2,
      MD_SQUARE  = 3'd3,
      MD_SWSTB   = 3'd4,
      MD_HWSTB   = 3'd5
   } ivt_mode_e;

   typedef struct packed {
      logic reload;
      logic reload_even;
      logic dec1;
      logic dec2;
   } ivt_cmd_t;

   // codes 6 and 7 fold onto 2 and 3
   function automatic ivt_mode_e ivt_norm_mode(input logic [2:0] raw);
      if (raw[2] && raw[1]) return ivt_mode_e'({1'b0, raw[1:0]});
      return ivt_mode_e'(raw);
   endfunction

endpackage

// File: rtl/ivt_gate_sense.sv
`timescale 1ns/1ps
module ivt_gate_sense #(
   parameter int SYNC_STAGES = 0,
   parameter bit GATE_RST    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_in,
   output logic gate_lvl,
   output logic gate_rise
);

   logic gate_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign gate_lvl = gate_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= {SYNC_STAGES{GATE_RST}};
            end else begin
               sync_q[0] <= gate_in;
               for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign gate_lvl = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= GATE_RST;
      else        gate_q <= gate_lvl;
   end

   assign gate_rise = gate_lvl & ~gate_q;

   // an edge is reported for a single cycle only
   p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gate_rise |=> !gate_rise);

endmodule

// File: rtl/ivt_down_counter.sv
`timescale 1ns/1ps
module ivt_down_counter import ivt_pkg::*; #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [CNT_W-1:0] wr_count,
   input  ivt_cmd_t         cmd,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] STEP1 = CNT_W'(1);
   localparam logic [CNT_W-1:0] STEP2 = CNT_W'(2);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rel_q <= '0;
      end else if (wr_stb) begin
         cnt_q <= wr_count;
         rel_q <= wr_count;
      end else if (cmd.reload) begin
         cnt_q <= rel_q;
      end else if (cmd.reload_even) begin
         cnt_q <= {rel_q[CNT_W-1:1], 1'b0};
      end else if (cmd.dec2) begin
         cnt_q <= cnt_q - STEP2;
      end else if (cmd.dec1) begin
         cnt_q <= cnt_q - STEP1;
      end
   end

   assign cnt = cnt_q;

   // the sequencer never asks for two counter actions at once
   p_cmd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd));

   // with no command and no write the count holds
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == '0 && !wr_stb) |=> $stable(cnt_q));

endmodule

// File: rtl/ivt_seq.sv
`timescale 1ns/1ps
module ivt_seq import ivt_pkg::*; #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate_lvl,
   input  logic             gate_rise,
   input  logic             wr_stb,
   input  logic [2:0]       wr_mode,
   input  logic [CNT_W-1:0] cnt,
   output ivt_cmd_t         cmd,
   output logic             timer_out
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   ivt_mode_e mode_q, wr_norm;
   logic      out_q, out_n;
   logic      run_q, run_n;
   logic      start_q, start_n;
   logic      at_one, at_edge3;

   assign wr_norm  = ivt_norm_mode(wr_mode);
   assign at_one   = (cnt == ONE);
   assign at_edge3 = (cnt == ONE) || (cnt == TWO);

   always_comb begin
      cmd     = '0;
      out_n   = out_q;
      run_n   = run_q;
      start_n = start_q;
      case (mode_q)
         MD_TERM: begin
            if (tick && gate_lvl) begin
               cmd.dec1 = 1'b1;
               if (at_one) out_n = 1'b1;
            end
         end
         MD_ONESHOT: begin
            if (gate_rise) begin
               cmd.reload = 1'b1;
               out_n      = 1'b0;
               run_n      = 1'b1;
               start_n    = 1'b1;
            end else if (tick && start_q) begin
               cmd.dec1 = 1'b1;
               if (run_q && at_one) begin
                  out_n = 1'b1;
                  run_n = 1'b0;
               end
            end
         end
         MD_RATE: begin
            if (gate_rise) begin
               cmd.reload = 1'b1;
               out_n      = 1'b1;
            end else if (!gate_lvl) begin
               out_n = 1'b1;
            end else if (tick) begin
               if (at_one) begin
                  cmd.reload = 1'b1;
                  out_n      = 1'b0;
               end else begin
                  cmd.dec1 = 1'b1;
                  out_n    = 1'b1;
               end
            end
         end
         MD_SQUARE: begin
            if (gate_rise) begin
               cmd.reload = 1'b1;
               out_n      = 1'b1;
            end else if (!gate_lvl) begin
               out_n = 1'b1;
            end else if (tick) begin
               if (at_edge3) begin
                  out_n = ~out_q;
                  if (out_q) cmd.reload_even = 1'b1;
                  else       cmd.reload      = 1'b1;
               end else begin
                  cmd.dec2 = 1'b1;
               end
            end
         end
         MD_SWSTB: begin
            if (tick && gate_lvl) begin
               cmd.dec1 = 1'b1;
               out_n    = 1'b1;
               if (run_q && at_one) begin
                  out_n = 1'b0;
                  run_n = 1'b0;
               end
            end
         end
         MD_HWSTB: begin
            if (gate_rise) begin
               cmd.reload = 1'b1;
               out_n      = 1'b1;
               run_n      = 1'b1;
               start_n    = 1'b1;
            end else if (tick && start_q) begin
               cmd.dec1 = 1'b1;
               out_n    = 1'b1;
               if (run_q && at_one) begin
                  out_n = 1'b0;
                  run_n = 1'b0;
               end
            end
         end
         default: begin
            out_n = 1'b1;
         end
      endcase
      if (wr_stb) cmd = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MD_SQUARE;
         out_q   <= 1'b1;
         run_q   <= 1'b0;
         start_q <= 1'b0;
      end else if (wr_stb) begin
         mode_q  <= wr_norm;
         out_q   <= (wr_norm != MD_TERM);
         run_q   <= (wr_norm == MD_SWSTB);
         start_q <= 1'b0;
      end else begin
         out_q   <= out_n;
         run_q   <= run_n;
         start_q <= start_n;
      end
   end

   assign timer_out = out_q;

   p_term_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_TERM && out_q && !wr_stb) |=> out_q);

   p_oneshot_low_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_ONESHOT && !out_q) |-> run_q);

   p_gate_low_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MD_RATE || mode_q == MD_SQUARE) && !gate_lvl && !wr_stb)
         |=> ($stable(cnt) && out_q));

   p_strobe_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MD_SWSTB || mode_q == MD_HWSTB) && !out_q) |-> !run_q);

   p_rate_no_early_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> timer_out || (mode_q == MD_TERM));

endmodule

// File: rtl/ivt_snap.sv
`timescale 1ns/1ps
module ivt_snap #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snap_stb,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] snap_count
);

   logic [CNT_W-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snap_q <= '0;
      else if (snap_stb) snap_q <= cnt;
   end

   assign snap_count = snap_q;

   p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_stb |=> $stable(snap_q));

endmodule

// File: rtl/ivt_channel.sv
`timescale 1ns/1ps
module ivt_channel import ivt_pkg::*; #(
   parameter int CNT_W     = 16,
   parameter int GATE_SYNC = 0,
   parameter bit GATE_RST  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             gate_in,
   input  logic             wr_stb,
   input  logic [CNT_W-1:0] wr_count,
   input  logic [2:0]       wr_mode,
   input  logic             snap_stb,
   output logic [CNT_W-1:0] live_count,
   output logic [CNT_W-1:0] snap_count,
   output logic             timer_out
);

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
         $error("ivt_channel: CNT_W must lie in 4..32");
      end
      if (GATE_SYNC < 0 || GATE_SYNC > 3) begin : g_bad_sync
         $error("ivt_channel: GATE_SYNC must lie in 0..3");
      end
   endgenerate

   logic             gate_lvl, gate_rise;
   ivt_cmd_t         cmd;
   logic [CNT_W-1:0] cnt;

   ivt_gate_sense #(.SYNC_STAGES(GATE_SYNC), .GATE_RST(GATE_RST)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate_in   (gate_in),
      .gate_lvl  (gate_lvl),
      .gate_rise (gate_rise)
   );

   ivt_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_en),
      .gate_lvl  (gate_lvl),
      .gate_rise (gate_rise),
      .wr_stb    (wr_stb),
      .wr_mode   (wr_mode),
      .cnt       (cnt),
      .cmd       (cmd),
      .timer_out (timer_out)
   );

   ivt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_count (wr_count),
      .cmd      (cmd),
      .cnt      (cnt)
   );

   ivt_snap #(.CNT_W(CNT_W)) u_snap (
      .clk        (clk),
      .rst_n      (rst_n),
      .snap_stb   (snap_stb),
      .cnt        (cnt),
      .snap_count (snap_count)
   );

   assign live_count = cnt;

   p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> live_count == $past(wr_count));

   p_snap_copies_r11: assert property (@(posedge clk) disable iff (!rst_n)
      snap_stb |=> snap_count == $past(live_count));

endmodule

// File: tb/ivt_channel_test.sv
`timescale 1ns/1ps
module ivt_channel_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b1;
   logic         gate_in = 1'b1;
   logic         wr_stb = 1'b0;
   logic [W-1:0] wr_count = '0;
   logic [2:0]   wr_mode = '0;
   logic         snap_stb = 1'b0;
   logic [W-1:0] live_count, snap_count;
   logic         timer_out;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int t0 = 0;
   bit done = 1'b0;

   typedef struct {
      int           at;
      logic         out;
      logic [W-1:0] cnt;
      string        req;
   } exp_t;

   exp_t sbq[$];

   ivt_channel uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .gate_in    (gate_in),
      .wr_stb     (wr_stb),
      .wr_count   (wr_count),
      .wr_mode    (wr_mode),
      .snap_stb   (snap_stb),
      .live_count (live_count),
      .snap_count (snap_count),
      .timer_out  (timer_out)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected items as their cycle comes up
   always @(negedge clk) begin
      exp_t e;
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
         e = sbq.pop_front();
         checks++;
         if (e.at != cyc || timer_out !== e.out || live_count !== e.cnt) begin
            failures++;
            $display("FAIL %s at=%0d now=%0d out=%b exp=%b count=%h exp=%h",
                     e.req, e.at, cyc, timer_out, e.out, live_count, e.cnt);
         end
      end
   end

   task automatic chk(input bit ok, input string r, input longint act, input longint exv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exv);
      end
   endtask

   task automatic expect_at(input int dc, input logic o, input logic [W-1:0] c, input string r);
      exp_t e;
      e.at  = t0 + dc;
      e.out = o;
      e.cnt = c;
      e.req = r;
      sbq.push_back(e);
   endtask

   // driver: present a write at the current falling edge
   task automatic write(input logic [W-1:0] c, input logic [2:0] m);
      t0       = cyc;
      wr_count = c;
      wr_mode  = m;
      wr_stb   = 1'b1;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_stb   = 1'b0;
         snap_stb = 1'b0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R10: reset state
      run(3);
      chk(timer_out === 1'b1, "R10 reset out", timer_out, 1);
      chk(live_count === 16'h0000, "R10 reset count", live_count, 0);
      t0 = cyc;
      rst_n = 1'b1;
      expect_at(1, 1'b1, 16'hFFFE, "R10 square after reset");
      run(3);

      // R3 / R2: behaviour 0, count 5
      write(16'd5, 3'd0);
      expect_at(1, 1'b0, 16'd5, "R2 load");
      expect_at(5, 1'b0, 16'd1, "R3 still low");
      expect_at(6, 1'b1, 16'd0, "R3 rise after N");
      expect_at(7, 1'b1, 16'hFFFF, "R3 wraps");
      run(8);

      // R8: gate low pauses behaviour 0
      write(16'd4, 3'd0);
      expect_at(5, 1'b0, 16'd3, "R8 term hold");
      expect_at(7, 1'b0, 16'd1, "R8 term resume");
      expect_at(8, 1'b1, 16'd0, "R8 term done");
      run(2); gate_in = 1'b0;
      run(3); gate_in = 1'b1;
      run(4);

      // R4: one-shot, trigger and retrigger
      write(16'd3, 3'd1);
      expect_at(2, 1'b1, 16'd3, "R4 waits for trigger");
      expect_at(3, 1'b0, 16'd3, "R4 triggered");
      expect_at(5, 1'b0, 16'd1, "R4 counting");
      expect_at(6, 1'b1, 16'd0, "R4 done");
      expect_at(10, 1'b0, 16'd1, "R4 gate low keeps counting");
      expect_at(11, 1'b0, 16'd3, "R4 retrigger restarts");
      expect_at(14, 1'b1, 16'd0, "R4 done again");
      run(1); gate_in = 1'b0;
      run(1); gate_in = 1'b1;
      run(4); gate_in = 1'b0;
      run(1); gate_in = 1'b1;
      run(2); gate_in = 1'b0;
      run(1); gate_in = 1'b1;
      run(5);

      // R5 / R8: rate generator, count 3
      write(16'd3, 3'd2);
      expect_at(1, 1'b1, 16'd3, "R5 no pulse at load");
      expect_at(3, 1'b1, 16'd1, "R5 before pulse");
      expect_at(4, 1'b0, 16'd3, "R5 pulse and reload");
      expect_at(5, 1'b1, 16'd2, "R5 pulse ends");
      expect_at(7, 1'b0, 16'd3, "R5 second pulse");
      expect_at(8, 1'b1, 16'd3, "R8 rate gate low forces high");
      expect_at(9, 1'b1, 16'd3, "R8 rate holds");
      expect_at(11, 1'b1, 16'd2, "R8 rate restarts on rise");
      run(7); gate_in = 1'b0;
      run(2); gate_in = 1'b1;
      run(3);

      // R6: square wave, odd count 5
      write(16'd5, 3'd3);
      expect_at(3, 1'b1, 16'd1, "R6 high half");
      expect_at(4, 1'b0, 16'd4, "R6 low reload even");
      expect_at(5, 1'b0, 16'd2, "R6 low half");
      expect_at(6, 1'b1, 16'd5, "R6 high reload");
      expect_at(8, 1'b1, 16'd1, "R6 second period");
      expect_at(9, 1'b0, 16'd4, "R6 second low");
      run(10);

      // R9: code 7 acts as square wave, count 4
      write(16'd4, 3'd7);
      expect_at(2, 1'b1, 16'd2, "R9 code7 step two");
      expect_at(3, 1'b0, 16'd4, "R9 code7 low");
      expect_at(5, 1'b1, 16'd4, "R9 code7 high");
      run(6);

      // R7: software strobe, count 2
      write(16'd2, 3'd4);
      expect_at(1, 1'b1, 16'd2, "R7 sw load");
      expect_at(3, 1'b0, 16'd0, "R7 sw strobe");
      expect_at(4, 1'b1, 16'hFFFF, "R7 sw no reload");
      expect_at(5, 1'b1, 16'hFFFE, "R7 sw single strobe");
      run(6);

      // R7: gate-started strobe, count 2
      write(16'd2, 3'd5);
      expect_at(2, 1'b1, 16'd2, "R7 hw waits");
      expect_at(4, 1'b1, 16'd1, "R7 hw counting");
      expect_at(5, 1'b0, 16'd0, "R7 hw strobe");
      expect_at(6, 1'b1, 16'hFFFF, "R7 hw no reload");
      run(1); gate_in = 1'b0;
      run(1); gate_in = 1'b1;
      run(5);

      // R9: code 6 acts as rate generator, count 2
      write(16'd2, 3'd6);
      expect_at(1, 1'b1, 16'd2, "R9 code6 load");
      expect_at(3, 1'b0, 16'd2, "R9 code6 pulse");
      expect_at(4, 1'b1, 16'd1, "R9 code6 after pulse");
      run(5);

      // R2: tick enable gates counting
      tick_en = 1'b0;
      write(16'd3, 3'd0);
      expect_at(1, 1'b0, 16'd3, "R2 no tick load");
      expect_at(4, 1'b0, 16'd3, "R2 no tick hold");
      expect_at(5, 1'b0, 16'd2, "R2 tick resumes");
      run(4); tick_en = 1'b1;
      run(3);

      // R11: snapshot
      write(16'd100, 3'd0);
      run(1); snap_stb = 1'b1;
      run(1);
      chk(snap_count === 16'd100, "R11 snap captured", snap_count, 100);
      run(1);
      chk(snap_count === 16'd100, "R11 snap held", snap_count, 100);
      chk(live_count === 16'd98, "R11 live moves on", live_count, 98);

      // R1: zero count spans 65536 ticks
      write(16'd0, 3'd0);
      expect_at(65536, 1'b0, 16'd1, "R1 zero still low");
      expect_at(65537, 1'b1, 16'd0, "R1 zero rise");
      run(65538);

      finish_run();
   end

endmodule